// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Timer Counter

This block is a 16-bit up-counting timer reached through an 8-bit register port. Software starts and stops it, picks a clock divider, and sets a 16-bit compare value. Each time the counter advances while its value equals the compare value, a sticky match flag is set. When interrupts are enabled, that flag drives the interrupt output. In an optional mode the counter returns to zero on a match instead of incrementing, which turns the compare value into a period.

The count is reached as two bytes, and 16-bit accesses take the low byte first. A read of the low byte captures the high byte into a shadow register, and the following high-byte read returns that captured copy. A write to the low byte is held in a staging register, and a write to the high byte then loads all 16 bits at once. Both count bytes can be read at any time. Writes to them are discarded while the timer runs.

Top module: `byte_timer`

## Requirements
- R1: After reset, the count, control, compare and match flag read as zero, and irq_o is low.
- R2: Register offsets on addr_i: 0 is control, 1 is status, 2 and 3 are the compare low and high bytes, 4 and 5 are the count low and high bytes. Offsets 6 and 7 read as zero. Control bits: bit 0 run, bits 2:1 divider select, bit 3 interrupt enable, bit 4 clear-on-match. Status bit 0 is the match flag. Reads are combinational while rd_en_i is high.
- R3: While run is set, the counter advances once every 2^sel clocks. The first advance comes 2^sel clocks after the edge that sets run. With run clear, the divider phase is held at zero.
- R4: Without clear-on-match, the count steps from 0xFFFF to 0x0000.
- R5: With clear-on-match set, an advance that finds the count equal to the compare value loads zero.
- R6: An advance that finds the count equal to the compare value sets the match flag. The flag stays set until a write to the status register with bit 0 at 1. If a set and a clear fall on the same edge, the set wins.
- R7: irq_o is high exactly when both the match flag and the interrupt enable are set.
- R8: Reading the count low byte captures the current high byte into a shadow register. Reading the count high byte returns that shadow value.
- R9: While stopped, a write to the count low byte goes to a staging register, and a write to the count high byte loads {high data, staged low byte} into the counter on one edge.
- R10: While run is set, writes to either count byte change neither the counter nor the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a low count-byte read captures the shadow |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when rd_en_i is low |
| irq_o | output | 1 | Match interrupt |

## Verification
The counter is run at divider settings 1 and 4, and each result is compared against a clock-accurate model. This catches an off-by-one in the divider phase. A run from 0xFFFE past the top checks the plain wrap, and a short period with clear-on-match checks the return to zero. A compare value of zero with clear-on-match produces a match on every clock, which is used to show that a set wins over a simultaneous write-one-to-clear. Count writes made while running are followed by a stop and a high-byte-only write, so the untouched staging byte appears at the port, and a low read followed by a delayed high read shows that the shadow is held.

// File: rtl/bt_pkg.sv
package bt_pkg;
  parameter int ADDR_W    = 3;
  parameter int PSC_SEL_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd5;

  typedef struct packed {
    logic                 clr_on_match;
    logic                 irq_en;
    logic [PSC_SEL_W-1:0] psc_sel;
    logic                 run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  always_comb mask = PC_W'((1 << sel_i) - 1);

  assign tick_o = run_i && ((pc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_i) pc_q <= pc_q + 1'b1;
    else            pc_q <= '0;
  end
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_on_match_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              match_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] stage_q;
  logic              eq;

  assign eq      = (cnt_q == cmp_i);
  assign match_o = tick_i && eq;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      if (tick_i)       cnt_q <= (clr_on_match_i && eq) ? '0 : cnt_q + 1'b1;
      else if (wr_hi_i) cnt_q <= {wdata_i, stage_q};
      if (wr_lo_i)      stage_q <= wdata_i;
    end
  end
endmodule

// File: rtl/bt_regs.sv
module bt_regs
  import bt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              flag_o,
  output logic              wr_cnt_lo_o,
  output logic              wr_cnt_hi_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              flag_q;
  logic [BYTE_W-1:0] shadow_q;
  logic [BYTE_W-1:0] rd_mux;

  assign wr_cnt_lo_o = wr_en_i && (addr_i == ADR_CNT_LO) && !ctrl_q.run;
  assign wr_cnt_hi_o = wr_en_i && (addr_i == ADR_CNT_HI) && !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      cmp_q    <= '0;
      flag_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADR_CTRL)   ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_en_i && addr_i == ADR_CMP_LO) cmp_q[BYTE_W-1:0] <= wdata_i;
      if (wr_en_i && addr_i == ADR_CMP_HI) cmp_q[CNT_W-1:BYTE_W] <= wdata_i;
      // set has priority over write-one-to-clear
      if (match_i)                                         flag_q <= 1'b1;
      else if (wr_en_i && addr_i == ADR_STAT && wdata_i[0]) flag_q <= 1'b0;
      if (rd_en_i && addr_i == ADR_CNT_LO) shadow_q <= cnt_i[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    case (addr_i)
      ADR_CTRL:   rd_mux = BYTE_W'(ctrl_q);
      ADR_STAT:   rd_mux = BYTE_W'(flag_q);
      ADR_CMP_LO: rd_mux = cmp_q[BYTE_W-1:0];
      ADR_CMP_HI: rd_mux = cmp_q[CNT_W-1:BYTE_W];
      ADR_CNT_LO: rd_mux = cnt_i[BYTE_W-1:0];
      ADR_CNT_HI: rd_mux = shadow_q;
      default:    rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_en_i ? rd_mux : '0;
  assign irq_o   = flag_q && ctrl_q.irq_en;
  assign ctrl_o  = ctrl_q;
  assign cmp_o   = cmp_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/byte_timer.sv
module byte_timer
  import bt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             tick;
  logic             match;
  logic             flag;
  logic             wr_lo;
  logic             wr_hi;

  bt_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .cnt_i(cnt), .match_i(match), .ctrl_o(ctrl), .cmp_o(cmp), .flag_o(flag),
    .wr_cnt_lo_o(wr_lo), .wr_cnt_hi_o(wr_hi), .rdata_o, .irq_o
  );

  bt_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk_i, .rst_ni, .run_i(ctrl.run), .sel_i(ctrl.psc_sel), .tick_o(tick)
  );

  bt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .clr_on_match_i(ctrl.clr_on_match),
    .cmp_i(cmp), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i,
    .cnt_o(cnt), .match_o(match)
  );
endmodule

// File: rtl/bt_chk.sv
module bt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             run_i,
  input logic             clr_i,
  input logic             ie_i,
  input logic             flag_i,
  input logic             load_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic             irq_i
);
  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_i));
  // R4
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(clr_i && cnt_i == cmp_i)) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));
  // R5
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && clr_i && cnt_i == cmp_i) |=> (cnt_i == '0));
  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == cmp_i) |=> flag_i);
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flag_i && ie_i));
  // R3
  tick_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> run_i);
endmodule

bind byte_timer bt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(ctrl.run),
  .clr_i(ctrl.clr_on_match), .ie_i(ctrl.irq_en), .flag_i(flag),
  .load_i(wr_hi), .cnt_i(cnt), .cmp_i(cmp), .irq_i(irq_o)
);

// File: tb/byte_timer_tb.sv
module byte_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  byte_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .rd_en_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  int m_run, m_sel, m_ie, m_clr, m_cmp, m_flag, m_cnt, m_stage, m_shadow, m_phase;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_sel = 0; m_ie = 0; m_clr = 0; m_cmp = 0;
      m_flag = 0; m_cnt = 0; m_stage = 0; m_shadow = 0; m_phase = 0;
    end else begin
      int div, tk, hit, n_cnt, n_flag, n_stage, n_shadow;
      div = 1 << m_sel;
      tk = (m_run != 0) && ((m_phase % div) == div - 1);
      hit = tk && (m_cnt == m_cmp);
      n_cnt = m_cnt; n_flag = m_flag; n_stage = m_stage; n_shadow = m_shadow;
      if (tk) n_cnt = (hit && m_clr != 0) ? 0 : (m_cnt + 1) % 65536;
      else if (we && addr == 5 && m_run == 0) n_cnt = (int'(wdata) << 8) | m_stage;
      if (we && addr == 4 && m_run == 0) n_stage = wdata;
      if (hit) n_flag = 1;
      else if (we && addr == 1 && wdata[0]) n_flag = 0;
      if (re && addr == 4) n_shadow = m_cnt >> 8;
      m_phase = (m_run != 0) ? m_phase + 1 : 0;
      if (we && addr == 0) begin
        m_run = wdata[0]; m_sel = wdata[2:1]; m_ie = wdata[3]; m_clr = wdata[4];
      end
      if (we && addr == 2) m_cmp = (m_cmp & 16'hFF00) | wdata;
      if (we && addr == 3) m_cmp = (m_cmp & 16'h00FF) | (int'(wdata) << 8);
      m_cnt = n_cnt; m_flag = n_flag; m_stage = n_stage; m_shadow = n_shadow;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_run | (m_sel << 1) | (m_ie << 3) | (m_clr << 4);
      1: return m_flag;
      2: return m_cmp & 255;
      3: return m_cmp >> 8;
      4: return m_cnt & 255;
      5: return m_shadow;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R7: interrupt compared against the model on every clock
  always @(negedge clk) if (rst_n && !done) chk("R7", int'(irq), m_flag & m_ie);

  task automatic wr(int a, int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(string req, int a, output int v);
    @(negedge clk); addr = 3'(a); re = 1'b1;
    #2; v = int'(rdata); chk(req, v, exp_rd(a));
    @(negedge clk); re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1, R2: reset values across the map
    for (int a = 0; a < 8; a++) begin rd("R1", a, v); chk("R1", v, 0); end
    chk("R1", int'(irq), 0);

    // R9, R8: staged 16-bit load while stopped
    wr(4, 8'h34); wr(5, 8'h12);
    rd("R8", 4, lo); rd("R8", 5, hi);
    chk("R9", (hi << 8) | lo, 16'h1234);

    // R3: divide by 1, then by 4
    wr(2, 8'hFF); wr(3, 8'hFF);
    wr(0, 8'h01); idle(9); wr(0, 8'h00);
    rd("R3", 4, v); rd("R3", 5, v);
    wr(4, 0); wr(5, 0);
    wr(0, 8'h05); idle(21); wr(0, 8'h00);
    rd("R3", 4, v); rd("R3", 5, v);

    // R10: count writes while running are dropped, staging untouched
    wr(4, 8'h34); wr(5, 8'h00);
    wr(0, 8'h01); wr(4, 8'hAA); wr(5, 8'hBB); wr(0, 8'h00);
    rd("R10", 4, v); rd("R10", 5, v);
    wr(5, 8'h55);
    rd("R10", 4, lo); rd("R10", 5, hi);
    chk("R10", (hi << 8) | lo, 16'h5534);

    // R4: wrap past 0xFFFF
    wr(2, 8'h00); wr(3, 8'h80);
    wr(4, 8'hFE); wr(5, 8'hFF);
    wr(0, 8'h01); wr(0, 8'h00);
    rd("R4", 4, lo); rd("R4", 5, hi);
    chk("R4", (hi < 8) ? 1 : 0, 1);

    // R5, R6, R7: clear-on-match with period cmp+1
    wr(2, 8'h05); wr(3, 8'h00);
    wr(4, 0); wr(5, 0);
    wr(0, 8'h19); idle(17);
    rd("R5", 4, v); chk("R5", (v <= 5) ? 1 : 0, 1);
    rd("R5", 5, v); chk("R5", v, 0);
    rd("R6", 1, v); chk("R6", v, 1);
    chk("R7", int'(irq), 1);

    // R6: match every clock, set beats write-one-to-clear
    wr(2, 8'h00); wr(0, 8'h18); wr(4, 0); wr(5, 0);
    wr(0, 8'h19); idle(2);
    wr(1, 8'h01);
    rd("R6", 1, v); chk("R6", v, 1);
    wr(0, 8'h08); wr(1, 8'h01);
    rd("R6", 1, v); chk("R6", v, 0);
    chk("R7", int'(irq), 0);

    // R8: shadow holds across a delayed high read
    wr(4, 8'hF0); wr(5, 8'h03);
    wr(0, 8'h01);
    idle(5); rd("R8", 4, v); idle(40); rd("R8", 5, hi);
    chk("R8", hi, 3);
    wr(0, 8'h00);
    rd("R2", 0, v); chk("R2", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule